// File: doc/BRIEF.md
# Linear Circuit-Switched Stream Switch

This block is one node of a one-dimensional chain of switches that links modules by dedicated circuits. Each node has a set of lanes to its right neighbour and a set of lanes to its left neighbour. It also has local producer ports, where a module starts a stream, and local consumer ports, where a module receives one. A producer raises a request that carries the index of the destination node. Every switch on the way claims one free outgoing lane in the direction of that index and passes the request on. At the destination node the request goes out on a local consumer port.

When a switch finds every lane in the needed direction taken, it answers with a deny, which travels back to the producer. The producer keeps the circuit only as long as it holds the request. Dropping the request frees the lanes hop by hop. Data words, each with a valid bit, follow the reserved circuit forward through registered multiplexers. A backpressure flag travels the same circuit in reverse. Each input lane has its own allocation state, so unrelated circuits through one switch work side by side.

Top module: `lin_stream_switch`

## Requirements
- R1: After reset, no lane is reserved and every request, valid, deny and backpressure output is low.
- R2: A request whose destination index is above the node position takes a right-going lane. One below it takes a left-going lane. One equal to it takes a local consumer port.
- R3: A request takes the lowest-numbered free outgoing lane or port in its direction group. For example, with two local consumer ports, the first stream to arrive at a node lands on port 0 and the second on port 1.
- R4: When several unreserved inputs want the same outgoing lane in one cycle, the lowest-numbered input wins. Local producers are numbered below inputs from the left, which are numbered below inputs from the right. A loser is not denied in that cycle. It retries, and it succeeds once a lane frees.
- R5: An input that holds a request, owns no lane and finds no free lane in its direction group sees its deny output go high. The deny stays high while that condition lasts.
- R6: When the owner of a reserved lane drops its request, the lane becomes free one cycle after the drop is registered. The lane can then carry a new circuit.
- R7: Words sent on an established circuit arrive at the consumer port in the order they were sent, with no loss and no duplicates. An outgoing valid is never high without its outgoing request.
- R8: A backpressure flag raised at a consumer port reaches the producer of that circuit, delayed by one register per switch.
- R9: A deny raised by a switch further along a circuit is passed back to the producer, one register per hop.
- R10: Circuits that share no lane carry data at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| p_req | input | KI | Local producer request, one per port |
| p_dst | input | KI*DW | Destination node index per local producer |
| p_vld | input | KI | Local producer data valid |
| p_data | input | KI*W | Local producer data |
| p_deny | output | KI | Deny back to local producer |
| p_full | output | KI | Backpressure back to local producer |
| fl_req | input | KR | Request on lanes arriving from the left neighbour |
| fl_dst | input | KR*DW | Destination index on lanes from the left |
| fl_vld | input | KR | Valid on lanes from the left |
| fl_data | input | KR*W | Data on lanes from the left |
| fl_deny | output | KR | Deny returned to the left neighbour |
| fl_full | output | KR | Backpressure returned to the left neighbour |
| fr_req | input | KL | Request on lanes arriving from the right neighbour |
| fr_dst | input | KL*DW | Destination index on lanes from the right |
| fr_vld | input | KL | Valid on lanes from the right |
| fr_data | input | KL*W | Data on lanes from the right |
| fr_deny | output | KL | Deny returned to the right neighbour |
| fr_full | output | KL | Backpressure returned to the right neighbour |
| tr_req | output | KR | Request on lanes going to the right neighbour |
| tr_dst | output | KR*DW | Destination index on lanes to the right |
| tr_vld | output | KR | Valid on lanes to the right |
| tr_data | output | KR*W | Data on lanes to the right |
| tr_deny | input | KR | Deny from the right neighbour |
| tr_full | input | KR | Backpressure from the right neighbour |
| tl_req | output | KL | Request on lanes going to the left neighbour |
| tl_dst | output | KL*DW | Destination index on lanes to the left |
| tl_vld | output | KL | Valid on lanes to the left |
| tl_data | output | KL*W | Data on lanes to the left |
| tl_deny | input | KL | Deny from the left neighbour |
| tl_full | input | KL | Backpressure from the left neighbour |
| c_req | output | KO | Circuit present at local consumer port |
| c_vld | output | KO | Data valid at local consumer port |
| c_data | output | KO*W | Data at local consumer port |
| c_full | input | KO | Backpressure from local consumer |

## Verification
The bench chains four nodes and goes after the following cases:
- Two producers in one node ask for the single right-going lane in the same cycle. A wrong arbiter would grant both, deny the winner, or deny the loser forever even after the lane frees.
- A circuit runs into a busy lane two hops away. A design that dropped the downstream deny would leave the producer waiting with no answer.
- After release, the same lanes and consumer port are requested again. A design that leaked a reservation would deny the new circuit or put it on a higher port.
- Two streams arrive at the same node's consumer ports at once, while a leftward and a rightward circuit run in parallel. Delivered words are compared one by one against the values sent, so any reordering or crossing of streams shows.

// File: rtl/lin_stream_switch.sv
module lin_stream_switch #(
  parameter int W     = 8,
  parameter int KL    = 1,
  parameter int KR    = 1,
  parameter int KI    = 2,
  parameter int KO    = 2,
  parameter int NODES = 4,
  parameter int POS   = 0,
  localparam int DW   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KI-1:0]   p_req,
  input  logic [KI*DW-1:0] p_dst,
  input  logic [KI-1:0]   p_vld,
  input  logic [KI*W-1:0] p_data,
  output logic [KI-1:0]   p_deny,
  output logic [KI-1:0]   p_full,
  input  logic [KR-1:0]   fl_req,
  input  logic [KR*DW-1:0] fl_dst,
  input  logic [KR-1:0]   fl_vld,
  input  logic [KR*W-1:0] fl_data,
  output logic [KR-1:0]   fl_deny,
  output logic [KR-1:0]   fl_full,
  input  logic [KL-1:0]   fr_req,
  input  logic [KL*DW-1:0] fr_dst,
  input  logic [KL-1:0]   fr_vld,
  input  logic [KL*W-1:0] fr_data,
  output logic [KL-1:0]   fr_deny,
  output logic [KL-1:0]   fr_full,
  output logic [KR-1:0]   tr_req,
  output logic [KR*DW-1:0] tr_dst,
  output logic [KR-1:0]   tr_vld,
  output logic [KR*W-1:0] tr_data,
  input  logic [KR-1:0]   tr_deny,
  input  logic [KR-1:0]   tr_full,
  output logic [KL-1:0]   tl_req,
  output logic [KL*DW-1:0] tl_dst,
  output logic [KL-1:0]   tl_vld,
  output logic [KL*W-1:0] tl_data,
  input  logic [KL-1:0]   tl_deny,
  input  logic [KL-1:0]   tl_full,
  output logic [KO-1:0]   c_req,
  output logic [KO-1:0]   c_vld,
  output logic [KO*W-1:0] c_data,
  input  logic [KO-1:0]   c_full
);
  localparam int NS = KI + KR + KL;
  localparam int NT = KR + KL + KO;
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;
  localparam int TW = (NT > 1) ? $clog2(NT) : 1;

  logic [NS-1:0]          req_r, vld_r, deny_q, full_q;
  logic [NS-1:0][DW-1:0]  dst_r;
  logic [NS-1:0][W-1:0]   dat_r;
  logic [NT-1:0]          busy, o_req, o_vld, t_deny, t_full;
  logic [NT-1:0][SW-1:0]  owner;
  logic [NT-1:0][W-1:0]   o_dat;
  logic [KR+KL-1:0][DW-1:0] o_dst;
  logic [NS-1:0]          owned, cand, nofree;
  logic [NS-1:0][TW-1:0]  own_t, pick;
  logic [NT-1:0]          gnt_v;
  logic [NT-1:0][SW-1:0]  gnt_s;

  assign t_deny = {{KO{1'b0}}, tl_deny, tr_deny};
  assign t_full = {c_full, tl_full, tr_full};

  function automatic int grp_lo(input logic [DW-1:0] d);
    if (int'(d) > POS) return 0;
    if (int'(d) < POS) return KR;
    return KR + KL;
  endfunction

  function automatic int grp_hi(input logic [DW-1:0] d);
    if (int'(d) > POS) return KR;
    if (int'(d) < POS) return KR + KL;
    return NT;
  endfunction

  always_comb begin
    owned = '0;
    own_t = '0;
    for (int t = 0; t < NT; t++)
      if (busy[t]) begin
        owned[owner[t]] = 1'b1;
        own_t[owner[t]] = TW'(t);
      end
    cand = '0;
    pick = '0;
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NT; t++)
        if (!cand[s] && !busy[t] && t >= grp_lo(dst_r[s]) && t < grp_hi(dst_r[s])) begin
          cand[s] = 1'b1;
          pick[s] = TW'(t);
        end
    gnt_v = '0;
    gnt_s = '0;
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < NS; s++)
        if (!gnt_v[t] && req_r[s] && !owned[s] && cand[s] && pick[s] == TW'(t)) begin
          gnt_v[t] = 1'b1;
          gnt_s[t] = SW'(s);
        end
    nofree = req_r & ~owned & ~cand;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_r  <= '0;
      vld_r  <= '0;
      dst_r  <= '0;
      dat_r  <= '0;
      busy   <= '0;
      owner  <= '0;
      o_req  <= '0;
      o_vld  <= '0;
      o_dat  <= '0;
      o_dst  <= '0;
      deny_q <= '0;
      full_q <= '0;
    end else begin
      req_r <= {fr_req, fl_req, p_req};
      vld_r <= {fr_vld, fl_vld, p_vld};
      dst_r <= {fr_dst, fl_dst, p_dst};
      dat_r <= {fr_data, fl_data, p_data};
      for (int t = 0; t < NT; t++) begin
        if (busy[t] && !req_r[owner[t]]) busy[t] <= 1'b0;
        else if (gnt_v[t]) begin
          busy[t]  <= 1'b1;
          owner[t] <= gnt_s[t];
        end
        o_req[t] <= busy[t] && req_r[owner[t]];
        o_vld[t] <= busy[t] && req_r[owner[t]] && vld_r[owner[t]];
        o_dat[t] <= dat_r[owner[t]];
      end
      for (int t = 0; t < KR + KL; t++) o_dst[t] <= dst_r[owner[t]];
      for (int s = 0; s < NS; s++) begin
        deny_q[s] <= req_r[s] && (nofree[s] || (owned[s] && t_deny[own_t[s]]));
        full_q[s] <= owned[s] && t_full[own_t[s]];
      end
    end
  end

  assign p_deny  = deny_q[KI-1:0];
  assign fl_deny = deny_q[KI+KR-1:KI];
  assign fr_deny = deny_q[NS-1:KI+KR];
  assign p_full  = full_q[KI-1:0];
  assign fl_full = full_q[KI+KR-1:KI];
  assign fr_full = full_q[NS-1:KI+KR];

  assign tr_req  = o_req[KR-1:0];
  assign tr_vld  = o_vld[KR-1:0];
  assign tr_data = o_dat[KR-1:0];
  assign tr_dst  = o_dst[KR-1:0];
  assign tl_req  = o_req[KR+KL-1:KR];
  assign tl_vld  = o_vld[KR+KL-1:KR];
  assign tl_data = o_dat[KR+KL-1:KR];
  assign tl_dst  = o_dst[KR+KL-1:KR];
  assign c_req   = o_req[NT-1:KR+KL];
  assign c_vld   = o_vld[NT-1:KR+KL];
  assign c_data  = o_dat[NT-1:KR+KL];
endmodule

// File: rtl/lin_stream_switch_chk.sv
module lin_stream_switch_chk #(
  parameter int NS = 4,
  parameter int NT = 4,
  parameter int SW = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NT-1:0]         busy,
  input logic [NT-1:0][SW-1:0] owner,
  input logic [NS-1:0]         req_r,
  input logic [NT-1:0]         o_req,
  input logic [NT-1:0]         o_vld,
  input logic [NT-1:0]         gnt_v
);
  logic [NS-1:0][NT-1:0] own_map;

  always_comb
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NT; t++)
        own_map[s][t] = busy[t] && (owner[t] == SW'(s));

  for (genvar t = 0; t < NT; t++) begin : g_lane
    a_r6_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
      busy[t] && !req_r[owner[t]] |=> !busy[t]);
    a_r3_grant_reserves: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_v[t] |-> !busy[t] ##1 busy[t]);
    a_r1_req_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
      o_req[t] |-> $past(busy[t]));
    a_r7_vld_within_req: assert property (@(posedge clk) disable iff (!rst_n)
      o_vld[t] |-> o_req[t]);
  end

  for (genvar s = 0; s < NS; s++) begin : g_src
    a_r4_one_lane_per_input: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(own_map[s]) <= 1);
  end
endmodule

bind lin_stream_switch lin_stream_switch_chk #(.NS(NS), .NT(NT), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .owner(owner), .req_r(req_r),
  .o_req(o_req), .o_vld(o_vld), .gnt_v(gnt_v)
);

// File: tb/lin_stream_switch_tb.sv
module lin_stream_switch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0][1:0]      preq, pvld, pdeny, pfull, creq, cvld, cfull;
  logic [3:0][1:0][1:0] pdst;
  logic [3:0][1:0][7:0] pdata, cdata;
  logic [4:0]           r_req, r_vld, r_deny, r_full, l_req, l_vld, l_deny, l_full;
  logic [4:0][1:0]      r_dst, l_dst;
  logic [4:0][7:0]      r_data, l_data;

  assign r_req[0] = 1'b0;  assign r_vld[0] = 1'b0;
  assign r_dst[0] = '0;    assign r_data[0] = '0;
  assign r_deny[4] = 1'b0; assign r_full[4] = 1'b0;
  assign l_req[4] = 1'b0;  assign l_vld[4] = 1'b0;
  assign l_dst[4] = '0;    assign l_data[4] = '0;
  assign l_deny[0] = 1'b0; assign l_full[0] = 1'b0;

  for (genvar n = 0; n < 4; n++) begin : g_node
    lin_stream_switch #(.W(8), .KL(1), .KR(1), .KI(2), .KO(2), .NODES(4), .POS(n)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .p_req(preq[n]), .p_dst(pdst[n]), .p_vld(pvld[n]), .p_data(pdata[n]),
      .p_deny(pdeny[n]), .p_full(pfull[n]),
      .fl_req(r_req[n]), .fl_dst(r_dst[n]), .fl_vld(r_vld[n]), .fl_data(r_data[n]),
      .fl_deny(r_deny[n]), .fl_full(r_full[n]),
      .fr_req(l_req[n+1]), .fr_dst(l_dst[n+1]), .fr_vld(l_vld[n+1]), .fr_data(l_data[n+1]),
      .fr_deny(l_deny[n+1]), .fr_full(l_full[n+1]),
      .tr_req(r_req[n+1]), .tr_dst(r_dst[n+1]), .tr_vld(r_vld[n+1]), .tr_data(r_data[n+1]),
      .tr_deny(r_deny[n+1]), .tr_full(r_full[n+1]),
      .tl_req(l_req[n]), .tl_dst(l_dst[n]), .tl_vld(l_vld[n]), .tl_data(l_data[n]),
      .tl_deny(l_deny[n]), .tl_full(l_full[n]),
      .c_req(creq[n]), .c_vld(cvld[n]), .c_data(cdata[n]), .c_full(cfull[n])
    );
  end

  logic [7:0] rxb [4][2][64];
  int rxn [4][2];
  initial for (int n = 0; n < 4; n++) for (int k = 0; k < 2; k++) rxn[n][k] = 0;
  always @(negedge clk)
    for (int n = 0; n < 4; n++)
      for (int k = 0; k < 2; k++)
        if (rst_n && cvld[n][k]) begin
          if (rxn[n][k] < 64) rxb[n][k][rxn[n][k]] = cdata[n][k];
          rxn[n][k] = rxn[n][k] + 1;
        end

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_rx(input int n, input int k, input int mark, input int base,
                          input int cnt, input string tag);
    chk(rxn[n][k] - mark == cnt, tag, rxn[n][k] - mark, cnt);
    for (int i = 0; i < cnt; i++)
      if (mark + i < 64)
        chk(int'(rxb[n][k][mark+i]) == base + i, tag, int'(rxb[n][k][mark+i]), base + i);
  endtask

  initial begin
    int m0, m1;
    preq = '0; pdst = '0; pvld = '0; pdata = '0; cfull = '0;
    cyc(3);
    // R1 reset state
    chk(creq == '0 && cvld == '0, "R1 consumer outputs idle", int'(creq), 0);
    chk(pdeny == '0 && pfull == '0, "R1 producer feedback idle", int'(pdeny), 0);
    rst_n = 1'b1;
    cyc(2);
    chk(r_req[4:1] == '0 && l_req[3:0] == '0, "R1 lanes idle", int'(r_req), 0);

    // R10 / R2 / R3: two disjoint rightward circuits 0->1 and 2->3
    preq[0][0] = 1'b1; pdst[0][0] = 2'd1;
    preq[2][0] = 1'b1; pdst[2][0] = 2'd3;
    for (int i = 0; i < 20 && !(creq[1][0] && creq[3][0]); i++) @(negedge clk);
    chk(creq[1][0] == 1'b1, "R3 circuit 0->1 on port 0", int'(creq[1]), 1);
    chk(creq[3][0] == 1'b1, "R2 circuit 2->3 via right lane", int'(creq[3]), 1);
    m0 = rxn[1][0]; m1 = rxn[3][0];
    for (int i = 0; i < 8; i++) begin
      pvld[0][0] = 1'b1; pdata[0][0] = 8'(8'h10 + i);
      pvld[2][0] = 1'b1; pdata[2][0] = 8'(8'h80 + i);
      @(negedge clk);
    end
    pvld = '0;
    cyc(12);
    check_rx(1, 0, m0, 'h10, 8, "R7 R10 stream 0->1");
    check_rx(3, 0, m1, 'h80, 8, "R7 R10 stream 2->3");

    // R5: node 0 right lane exhausted
    preq[0][1] = 1'b1; pdst[0][1] = 2'd3;
    for (int i = 0; i < 10 && !pdeny[0][1]; i++) @(negedge clk);
    chk(pdeny[0][1] == 1'b1, "R5 deny on exhausted right lane", int'(pdeny[0][1]), 1);
    cyc(3);
    chk(pdeny[0][1] == 1'b1, "R5 deny held", int'(pdeny[0][1]), 1);
    chk(creq[3][1] == 1'b0, "R5 no circuit at node 3 port 1", int'(creq[3][1]), 0);
    preq[0][1] = 1'b0;
    cyc(4);
    chk(pdeny[0][1] == 1'b0, "R5 deny drops with request", int'(pdeny[0][1]), 0);

    // R9: deny from two hops downstream (node 2 right lane busy)
    preq[1][0] = 1'b1; pdst[1][0] = 2'd3;
    for (int i = 0; i < 20 && !pdeny[1][0]; i++) @(negedge clk);
    chk(pdeny[1][0] == 1'b1, "R9 downstream deny reaches producer", int'(pdeny[1][0]), 1);
    preq[1][0] = 1'b0;
    cyc(8);

    // R8: backpressure travels back over one hop
    cfull[3][0] = 1'b1;
    cyc(5);
    chk(pfull[2][0] == 1'b1, "R8 full reaches producer", int'(pfull[2][0]), 1);
    chk(pfull[0][0] == 1'b0, "R8 R10 other circuit unaffected", int'(pfull[0][0]), 0);
    cfull[3][0] = 1'b0;
    cyc(5);
    chk(pfull[2][0] == 1'b0, "R8 full clears", int'(pfull[2][0]), 0);

    // R6: release both circuits, then reuse the lanes across three hops
    preq[0][0] = 1'b0; preq[2][0] = 1'b0;
    cyc(8);
    chk(creq[1][0] == 1'b0 && creq[3][0] == 1'b0, "R6 circuits torn down", int'(creq[1]) + int'(creq[3]), 0);
    preq[0][1] = 1'b1; pdst[0][1] = 2'd3;
    for (int i = 0; i < 20 && !creq[3][0]; i++) @(negedge clk);
    chk(creq[3][0] == 1'b1, "R6 freed lanes reused, port 0", int'(creq[3]), 1);
    chk(pdeny[0][1] == 1'b0, "R6 no deny after release", int'(pdeny[0][1]), 0);
    m0 = rxn[3][0];
    for (int i = 0; i < 5; i++) begin
      pvld[0][1] = 1'b1; pdata[0][1] = 8'(8'h40 + i); @(negedge clk);
      pvld[0][1] = 1'b0; @(negedge clk);
    end
    cyc(15);
    check_rx(3, 0, m0, 'h40, 5, "R7 three-hop stream");

    // R2: leftward circuit 3->0 alongside the rightward one
    preq[3][0] = 1'b1; pdst[3][0] = 2'd0;
    for (int i = 0; i < 20 && !creq[0][0]; i++) @(negedge clk);
    chk(creq[0][0] == 1'b1, "R2 leftward circuit reaches node 0", int'(creq[0]), 1);
    m0 = rxn[0][0];
    for (int i = 0; i < 6; i++) begin
      pvld[3][0] = 1'b1; pdata[3][0] = 8'(8'hC0 + i); @(negedge clk);
    end
    pvld = '0;
    cyc(15);
    check_rx(0, 0, m0, 'hC0, 6, "R2 R7 leftward stream");

    // R3 / R4: two local producers target the own node in the same cycle
    preq[2][0] = 1'b1; pdst[2][0] = 2'd2;
    preq[2][1] = 1'b1; pdst[2][1] = 2'd2;
    for (int i = 0; i < 15 && !(creq[2][0] && creq[2][1]); i++) @(negedge clk);
    chk(creq[2] == 2'b11, "R3 both local ports in use", int'(creq[2]), 3);
    chk(pdeny[2] == 2'b00, "R4 loser not denied while a port is free", int'(pdeny[2]), 0);
    m0 = rxn[2][0]; m1 = rxn[2][1];
    for (int i = 0; i < 4; i++) begin
      pvld[2] = 2'b11; pdata[2][0] = 8'(8'h20 + i); pdata[2][1] = 8'(8'h30 + i);
      @(negedge clk);
    end
    pvld = '0;
    cyc(8);
    check_rx(2, 0, m0, 'h20, 4, "R4 winner on port 0");
    check_rx(2, 1, m1, 'h30, 4, "R3 next free port 1");

    // R4: contention for the single right lane at node 0
    preq = '0;
    cyc(10);
    preq[0] = 2'b11; pdst[0][0] = 2'd1; pdst[0][1] = 2'd1;
    cyc(8);
    chk(pdeny[0][0] == 1'b0 && creq[1][0] == 1'b1, "R4 lowest input wins", int'(creq[1]), 1);
    chk(pdeny[0][1] == 1'b1, "R4 loser denied after re-evaluation", int'(pdeny[0][1]), 1);
    preq[0][0] = 1'b0;
    for (int i = 0; i < 20 && !(creq[1] != 2'b00 && !pdeny[0][1]); i++) @(negedge clk);
    chk(pdeny[0][1] == 1'b0, "R4 R6 loser retried", int'(pdeny[0][1]), 0);
    chk(creq[1] != 2'b00, "R4 R6 loser circuit formed", int'(creq[1]), 1);
    preq = '0;
    cyc(5);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule